// File: doc/BRIEF.md
# Mode-Typed Control and Status Register Bank

This block is a small memory-mapped register bank on a word-addressed bus with separate read and write strobes. Each register has an access mode, and the mode sets how the register behaves. A read-write register stores what is written and drives it to the fabric. A read-only register samples values coming in from the fabric. A write-pulse register drives a written value to the fabric for a single clock cycle. The register cell also supports write-only and read-with-write-pulse modes, selected by parameter.

The bank has nine registers: a configuration register, a status register, a command register, and a parameterised array of read-address and write-address register pairs. Read data and the error flag are registered, so they appear one cycle after the strobe. Every stored field returns to its default value on a synchronous active-high reset.

Top module: `modereg_bank`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `fab_enable` is 1, `fab_tag` is 4'b0101, every base-address output is 0, `fab_start` and `fab_flush` are 0, `bus_rdata` is 0 and `bus_err` is 0.
- R2: The word map is: 0 configuration, 1 status, 2 command, 3+2i read-address entry i, 4+2i write-address entry i (i = 0..2). Every address from 9 upward is unmapped.
- R3: Configuration is read-write. Bit 0 is enable and bits 4:1 are tag. A write updates `fab_enable` and `fab_tag` on the next cycle. A read returns the stored value. Without a write to address 0 the value holds.
- R4: Command is write-pulse. Bit 0 is start and bit 1 is flush. A write drives the written bits on `fab_start`/`fab_flush` for exactly the cycle after the write strobe, and they are 0 on the cycle after that unless another write follows. A read of the command register returns 0.
- R5: Each array entry is read-write and holds a 28-bit address in bits 27:0. Written bits 31:28 are dropped and read back as 0. Entry i drives slice i of `fab_rd_base`/`fab_wr_base`.
- R6: Status is read-only. Bit 0 is idle, bit 1 is stalling and bits 9:2 are the burst count. It samples the fabric inputs every cycle and resets to idle=1 with all other bits 0. A write to address 1 leaves it unchanged.
- R7: `bus_rdata` carries the addressed value on the cycle after `bus_rd`, with unused upper bits 0. On every other cycle it is 0.
- R8: A read or write to an unmapped address raises `bus_err` for the following cycle only. Such a read returns 0, and such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Unmapped-access flag, one cycle |
| fab_enable | output | 1 | Configuration enable |
| fab_tag | output | 4 | Configuration tag |
| fab_idle | input | 1 | Idle indication from fabric |
| fab_stalling | input | 1 | Stall indication from fabric |
| fab_bursts | input | 8 | Completed-burst count from fabric |
| fab_start | output | 1 | Start pulse |
| fab_flush | output | 1 | Flush pulse |
| fab_rd_base | output | 84 | Read base addresses, entry i in bits 28i+27:28i |
| fab_wr_base | output | 84 | Write base addresses, entry i in bits 28i+27:28i |

## Verification
A behavioural reference model follows every bus access and is compared with all outputs on every cycle. Distinct values are written to every address and then read back; this exposes any decode swap between neighbouring array entries or between the read and write halves of a pair. Writes with upper bits set separate correct field truncation from wide storage. Back-to-back command writes show whether a pulse lasts one cycle or lingers. Status reads taken right after reset, after a write to the status register, and after the fabric inputs change separate the reset default, write blocking and live sampling from one another.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

   typedef enum logic [2:0] {
      ACC_RO,
      ACC_WO,
      ACC_RW,
      ACC_WP,
      ACC_RWP
   } acc_mode_e;

   localparam int unsigned IDX_CFG = 0;
   localparam int unsigned IDX_STS = 1;
   localparam int unsigned IDX_CMD = 2;
   localparam int unsigned IDX_ARR = 3;

   localparam int unsigned TAG_W   = 4;
   localparam int unsigned BURST_W = 8;
   localparam int unsigned CFG_W   = 1 + TAG_W;
   localparam int unsigned STS_W   = 2 + BURST_W;
   localparam int unsigned CMD_W   = 2;

   // enable=1 in bit 0, tag=0101 in bits 4:1
   localparam logic [CFG_W-1:0] CFG_DEFAULT = {4'b0101, 1'b1};
   // idle=1 in bit 0, stalling and count cleared
   localparam logic [STS_W-1:0] STS_DEFAULT = {{BURST_W{1'b0}}, 1'b0, 1'b1};

endpackage

// File: rtl/modereg_decode.sv
module modereg_decode #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NREG   = 9
)(
   input  logic              en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NREG-1:0]   sel_o,
   output logic              miss_o
);
   if (NREG < 1 || NREG > (2 ** ADDR_W)) begin : g_bad_size
      $error("modereg_decode: NREG does not fit the address width");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel_o[i] = en_i && (addr_i == ADDR_W'(i));
   end

   assign miss_o = en_i && !(|sel_o);
endmodule

// File: rtl/modereg_cell.sv
module modereg_cell
   import modereg_pkg::*;
#(
   parameter int unsigned      DATA_W  = 32,
   parameter int unsigned      W       = 8,
   parameter acc_mode_e        MODE    = ACC_RW,
   parameter logic [DATA_W-1:0] DEFAULT = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [W-1:0]      hw_i,
   output logic [W-1:0]      fab_o,
   output logic [DATA_W-1:0] rd_o
);
   if (W == 0 || W >= DATA_W) begin : g_bad_width
      $error("modereg_cell: W must be between 1 and DATA_W-1");
   end

   localparam int unsigned  PAD     = DATA_W - W;
   localparam logic [W-1:0] RST_VAL = DEFAULT[W-1:0];

   logic [W-1:0] q;
   logic [W-1:0] rd_val;
   wire          unused_hi = ^wdata_i[DATA_W-1:W];

   assign fab_o = q;
   assign rd_o  = {{PAD{1'b0}}, rd_val};

   if (MODE == ACC_RO) begin : g_ro
      wire unused_ro = ^{we_i, wdata_i[W-1:0]};
      always_ff @(posedge clk) begin
         if (rst) q <= RST_VAL;
         else     q <= hw_i;
      end
      assign rd_val = q;

      // a bus write never replaces the sampled fabric value
      assert_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
         we_i |=> (q == $past(hw_i)));
   end else if (MODE == ACC_RW || MODE == ACC_WO) begin : g_store
      wire unused_st = ^hw_i;
      always_ff @(posedge clk) begin
         if (rst)       q <= RST_VAL;
         else if (we_i) q <= wdata_i[W-1:0];
      end
      assign rd_val = (MODE == ACC_RW) ? q : '0;

      // stored value (R3, R5) holds when not written
      assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (rst)
         !we_i |=> $stable(q));
   end else begin : g_pulse
      always_ff @(posedge clk) begin
         if (rst)       q <= '0;
         else if (we_i) q <= wdata_i[W-1:0];
         else           q <= '0;
      end
      if (MODE == ACC_RWP) begin : g_rd_in
         assign rd_val = hw_i;
      end else begin : g_rd_zero
         wire unused_p = ^hw_i;
         assign rd_val = '0;
      end

      assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
         ((|q) && !we_i) |=> (q == '0));
   end
endmodule

// File: rtl/modereg_readout.sv
module modereg_readout #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NREG   = 9
)(
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        rd_i,
   input  logic [NREG-1:0]             sel_i,
   input  logic                        miss_i,
   input  logic [NREG-1:0][DATA_W-1:0] words_i,
   output logic [DATA_W-1:0]           rdata_o,
   output logic                        err_o
);
   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      for (int i = 0; i < NREG; i++) begin
         if (sel_i[i]) mux = mux | words_i[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         rdata_o <= rd_i ? mux : '0;
         err_o   <= miss_i;
      end
   end

   assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !rd_i |=> (rdata_o == '0));
   assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
      !miss_i |=> !err_o);
endmodule

// File: rtl/modereg_bank.sv
module modereg_bank
   import modereg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned ARRAY_LEN = 3,
   parameter int unsigned AW        = 28
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      bus_err,
   output logic                      fab_enable,
   output logic [TAG_W-1:0]          fab_tag,
   input  logic                      fab_idle,
   input  logic                      fab_stalling,
   input  logic [BURST_W-1:0]        fab_bursts,
   output logic                      fab_start,
   output logic                      fab_flush,
   output logic [ARRAY_LEN*AW-1:0]   fab_rd_base,
   output logic [ARRAY_LEN*AW-1:0]   fab_wr_base
);
   localparam int unsigned NREG = IDX_ARR + 2 * ARRAY_LEN;
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);

   if (ARRAY_LEN < 1 || AW >= DATA_W || STS_W >= DATA_W) begin : g_bad_cfg
      $error("modereg_bank: array length or field width out of range");
   end

   logic [NREG-1:0]             wsel, rsel;
   logic                        wmiss, rmiss;
   logic [NREG-1:0][DATA_W-1:0] words;
   logic [CFG_W-1:0]            cfg_fab;
   logic [STS_W-1:0]            sts_unused_fab;
   logic [CMD_W-1:0]            cmd_fab;

   modereg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_wdec (
      .en_i(bus_wr), .addr_i(bus_addr), .sel_o(wsel), .miss_o(wmiss));
   modereg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rdec (
      .en_i(bus_rd), .addr_i(bus_addr), .sel_o(rsel), .miss_o(rmiss));

   modereg_cell #(.DATA_W(DATA_W), .W(CFG_W), .MODE(ACC_RW),
                  .DEFAULT(DATA_W'(CFG_DEFAULT))) u_cfg (
      .clk, .rst, .we_i(wsel[IDX_CFG]), .wdata_i(bus_wdata), .hw_i('0),
      .fab_o(cfg_fab), .rd_o(words[IDX_CFG]));

   modereg_cell #(.DATA_W(DATA_W), .W(STS_W), .MODE(ACC_RO),
                  .DEFAULT(DATA_W'(STS_DEFAULT))) u_sts (
      .clk, .rst, .we_i(wsel[IDX_STS]), .wdata_i(bus_wdata),
      .hw_i({fab_bursts, fab_stalling, fab_idle}),
      .fab_o(sts_unused_fab), .rd_o(words[IDX_STS]));

   modereg_cell #(.DATA_W(DATA_W), .W(CMD_W), .MODE(ACC_WP)) u_cmd (
      .clk, .rst, .we_i(wsel[IDX_CMD]), .wdata_i(bus_wdata), .hw_i('0),
      .fab_o(cmd_fab), .rd_o(words[IDX_CMD]));

   for (genvar i = 0; i < ARRAY_LEN; i++) begin : g_arr
      modereg_cell #(.DATA_W(DATA_W), .W(AW), .MODE(ACC_RW)) u_rd (
         .clk, .rst, .we_i(wsel[IDX_ARR + 2*i]), .wdata_i(bus_wdata), .hw_i('0),
         .fab_o(fab_rd_base[i*AW +: AW]), .rd_o(words[IDX_ARR + 2*i]));
      modereg_cell #(.DATA_W(DATA_W), .W(AW), .MODE(ACC_RW)) u_wr (
         .clk, .rst, .we_i(wsel[IDX_ARR + 2*i + 1]), .wdata_i(bus_wdata), .hw_i('0),
         .fab_o(fab_wr_base[i*AW +: AW]), .rd_o(words[IDX_ARR + 2*i + 1]));
   end

   modereg_readout #(.DATA_W(DATA_W), .NREG(NREG)) u_rout (
      .clk, .rst, .rd_i(bus_rd), .sel_i(rsel), .miss_i(rmiss | wmiss),
      .words_i(words), .rdata_o(bus_rdata), .err_o(bus_err));

   assign fab_enable = cfg_fab[0];
   assign fab_tag    = cfg_fab[CFG_W-1:1];
   assign fab_start  = cmd_fab[0];
   assign fab_flush  = cmd_fab[1];

   assert_unmapped_flags_R8: assert property (@(posedge clk) disable iff (rst)
      ((bus_rd || bus_wr) && (bus_addr > LAST_ADDR)) |=> (bus_err && (bus_rdata == '0)));
   assert_mapped_no_err_R2: assert property (@(posedge clk) disable iff (rst)
      ((bus_rd || bus_wr) && (bus_addr <= LAST_ADDR)) |=> !bus_err);
   assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && (bus_addr == ADDR_W'(IDX_CMD))) |=> (bus_rdata == '0));
endmodule

// File: tb/modereg_bank_tb_top.sv
module modereg_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        fab_enable, fab_start, fab_flush;
   logic [3:0]  fab_tag;
   logic        fab_idle = 1'b0, fab_stalling = 1'b1;
   logic [7:0]  fab_bursts = 8'hAA;
   logic [N*28-1:0] fab_rd_base, fab_wr_base;

   int checks = 0, errors = 0, cyc = 0;
   bit started = 0;

   logic [4:0]  m_cfg;
   logic [9:0]  m_sts;
   logic [1:0]  m_cmd;
   logic [27:0] m_rd [N];
   logic [27:0] m_wr [N];
   logic [31:0] m_rdata;
   logic        m_err;

   modereg_bank dut_i (
      .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .bus_err,
      .fab_enable, .fab_tag, .fab_idle, .fab_stalling, .fab_bursts,
      .fab_start, .fab_flush, .fab_rd_base, .fab_wr_base);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      logic [31:0] rv;
      if (rst) begin
         m_cfg = 5'b01011; m_sts = 10'd1; m_cmd = '0; m_rdata = '0; m_err = 1'b0;
         for (int i = 0; i < N; i++) begin m_rd[i] = '0; m_wr[i] = '0; end
      end else begin
         rv = '0;
         if (bus_addr == 4'd0) rv = {27'd0, m_cfg};
         else if (bus_addr == 4'd1) rv = {22'd0, m_sts};
         for (int i = 0; i < N; i++) begin
            if (int'(bus_addr) == 3 + 2*i) rv = {4'd0, m_rd[i]};
            if (int'(bus_addr) == 4 + 2*i) rv = {4'd0, m_wr[i]};
         end
         m_rdata = bus_rd ? rv : '0;
         m_err = (bus_rd || bus_wr) && (bus_addr > 4'd8);
         m_cmd = (bus_wr && bus_addr == 4'd2) ? bus_wdata[1:0] : 2'b00;
         if (bus_wr) begin
            if (bus_addr == 4'd0) m_cfg = bus_wdata[4:0];
            for (int i = 0; i < N; i++) begin
               if (int'(bus_addr) == 3 + 2*i) m_rd[i] = bus_wdata[27:0];
               if (int'(bus_addr) == 4 + 2*i) m_wr[i] = bus_wdata[27:0];
            end
         end
         m_sts = {fab_bursts, fab_stalling, fab_idle};
      end
      started = 1;
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (started) begin
         check("R3 enable", {31'd0, fab_enable}, {31'd0, m_cfg[0]});
         check("R3 tag", {28'd0, fab_tag}, {28'd0, m_cfg[4:1]});
         check("R4 start", {31'd0, fab_start}, {31'd0, m_cmd[0]});
         check("R4 flush", {31'd0, fab_flush}, {31'd0, m_cmd[1]});
         for (int i = 0; i < N; i++) begin
            check("R5 read base", {4'd0, fab_rd_base[i*28 +: 28]}, {4'd0, m_rd[i]});
            check("R5 write base", {4'd0, fab_wr_base[i*28 +: 28]}, {4'd0, m_wr[i]});
         end
         check("R7 read data", bus_rdata, m_rdata);
         check("R8 error flag", {31'd0, bus_err}, {31'd0, m_err});
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] a, output logic [31:0] got);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      got = bus_rdata;
   endtask

   initial begin
      logic [31:0] got;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 enable", {31'd0, fab_enable}, 32'd1);
      check("R1 tag", {28'd0, fab_tag}, 32'h5);
      check("R1 bases", {31'd0, (|fab_rd_base) | (|fab_wr_base)}, 32'd0);
      check("R1 pulses", {30'd0, fab_start, fab_flush}, 32'd0);
      check("R1 rdata/err", {31'd0, (|bus_rdata) | bus_err}, 32'd0);
      // R6: first read after reset returns the status default
      rst = 1'b0; bus_rd = 1'b1; bus_addr = 4'd1;
      @(negedge clk);
      bus_rd = 1'b0;
      check("R6 status default", bus_rdata, 32'h001);
      check("R1 tag after release", {28'd0, fab_tag}, 32'h5);
      do_rd(4'd1, got);
      check("R6 status sampled", got, 32'h2AA);
      @(negedge clk);
      check("R7 rdata idle zero", bus_rdata, 32'd0);

      // R3: configuration
      do_rd(4'd0, got);
      check("R3 cfg default read", got, 32'h0B);
      do_wr(4'd0, 32'hFFFF_FFF4);
      check("R3 enable written", {31'd0, fab_enable}, 32'd0);
      check("R3 tag written", {28'd0, fab_tag}, 32'hA);
      do_rd(4'd0, got);
      check("R3 cfg read back", got, 32'h14);

      // R4: pulses
      do_wr(4'd2, 32'h3);
      check("R4 both pulses", {30'd0, fab_flush, fab_start}, 32'h3);
      @(negedge clk);
      check("R4 pulse ended", {30'd0, fab_flush, fab_start}, 32'h0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h1;
      @(negedge clk);
      check("R4 start only", {30'd0, fab_flush, fab_start}, 32'h1);
      bus_wdata = 32'h2;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R4 flush only", {30'd0, fab_flush, fab_start}, 32'h2);
      @(negedge clk);
      check("R4 idle again", {30'd0, fab_flush, fab_start}, 32'h0);
      do_rd(4'd2, got);
      check("R4 command reads zero", got, 32'd0);

      // R5 / R2: array entries with distinct values
      for (int i = 0; i < N; i++) begin
         do_wr(4'(3 + 2*i), 32'hF000_0000 | (32'h0A00_0010 + i));
         do_wr(4'(4 + 2*i), 32'hF000_0000 | (32'h0B00_0020 + i));
      end
      for (int i = 0; i < N; i++) begin
         do_rd(4'(3 + 2*i), got);
         check("R2 R5 read entry", got, 32'h0A00_0010 + i);
         do_rd(4'(4 + 2*i), got);
         check("R2 R5 write entry", got, 32'h0B00_0020 + i);
         check("R5 fabric read base", {4'd0, fab_rd_base[i*28 +: 28]}, 32'h0A00_0010 + i);
      end

      // R6: writes ignored, live sampling
      do_wr(4'd1, 32'hFFFF_FFFF);
      do_rd(4'd1, got);
      check("R6 write ignored", got, 32'h2AA);
      fab_idle = 1'b1; fab_stalling = 1'b0; fab_bursts = 8'h05;
      @(negedge clk);
      do_rd(4'd1, got);
      check("R6 new inputs", got, 32'h015);

      // R8: unmapped accesses
      do_rd(4'd9, got);
      check("R8 unmapped read data", got, 32'd0);
      check("R8 err after read", {31'd0, bus_err}, 32'd1);
      @(negedge clk);
      check("R8 err one cycle", {31'd0, bus_err}, 32'd0);
      do_wr(4'd15, 32'hFFFF_FFFF);
      check("R8 err after write", {31'd0, bus_err}, 32'd1);
      do_rd(4'd0, got);
      check("R8 cfg untouched", got, 32'h14);
      do_rd(4'd8, got);
      check("R8 last entry untouched", got, 32'h0B00_0022);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule